// File: doc/BRIEF.md
# Prioritised Interrupt Entry Arbiter

This block sits beside an embedded 8/16-bit processor core. It decides, at each instruction boundary, whether the core takes an interrupt. Four sources compete. Source 0 is non-maskable. Sources 1 (timer), 2 (DMA-complete) and 3 (host-raised request) are maskable and are gated by the core's interrupt-disable flag.

The block keeps a clear bit and a status flag for each source. When it accepts a source it latches the vector and wakes a waiting core. It then runs the entry sequence on its own: a dummy read, one internal cycle, then the stack pushes through a byte-wide write port. In the last cycle it presents the new program counter, bank, status byte and stack pointer for the core to load.

The core supplies its program counter, bank, status byte, stack pointer and emulation flag. The block snapshots these at acceptance.

Top module: `irqarb_top`

## Requirements
- R1: `insn_end` is sampled only while the block is idle. An accepted interrupt shows `irq_pending` high for exactly one cycle, the cycle after the sampling edge.
- R2: Source 0 is taken when `src_req[0]` is 1 and its clear bit is 0, whatever the disable flag (`core_psw` bit 2) says. Its `src_en` bit is ignored, it reports `irq_src` = 0, and it uses `nmi_vec`.
- R3: Accepting source 0 sets status flag 0 and clear bit 0. A request that stays high is therefore not taken again until the clear bit is released.
- R4: Maskable sources are eligible only when `core_psw` bit 2 is 0, and each one needs request, enable and a low clear bit. Priority runs from source 0 (highest), then 1, then 2, then 3, and `irq_src` reports the index taken.
- R5: Every maskable source uses `irq_vec`. Accepting any source sets its bit in `src_flag`.
- R6: `core_wake` pulses in the same cycle as `irq_pending`.
- R7: The sequence is: a dummy-read cycle (`dummy_rd`), one internal cycle, then one stack write per cycle. In native mode (`core_emu` = 0) the writes are bank, PC high, PC low, status. In emulation mode the bank write is left out and bit 4 of the pushed status byte is 0.
- R8: Each write goes to the current stack address, which then decrements. In emulation mode the high byte is forced to 0x01 and only the low byte wraps.
- R9: The cycle after the last write asserts `pc_load` for one cycle. In that cycle `pc_new` holds the vector, `pbr_new` is 0x00, `psw_new` is the sampled status with bit 2 set and bit 3 cleared, and `sp_new` is the decremented stack pointer.
- R10: A `clr_set` pulse sets the clear bits and clears the status flags it names. A `clr_drop` pulse releases the clear bits it names. Where both touch the same bit, the set wins.
- R11: Under reset all clear bits, status flags and outputs are 0 and nothing is pending.
- R12: A strobe on `insn_end` while an entry sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_end | input | 1 | Last cycle of an instruction |
| src_req | input | 4 | Request per source (0 NMI, 1 timer, 2 DMA, 3 host) |
| src_en | input | 4 | Enable per maskable source (bit 0 unused) |
| clr_set | input | 4 | Pulse: set clear bit, drop status flag |
| clr_drop | input | 4 | Pulse: release clear bit |
| nmi_vec | input | 16 | Non-maskable vector |
| irq_vec | input | 16 | Shared maskable vector |
| core_pc | input | 16 | Core program counter |
| core_pbr | input | 8 | Core program bank |
| core_psw | input | 8 | Core status byte (bit 2 disable, bit 3 decimal) |
| core_sp | input | 16 | Core stack pointer |
| core_emu | input | 1 | Core emulation mode |
| irq_pending | output | 1 | Interrupt accepted (one cycle) |
| irq_src | output | 2 | Accepted source index |
| irq_vector | output | 16 | Latched vector |
| core_wake | output | 1 | Release from wait-for-interrupt |
| dummy_rd | output | 1 | Dummy read cycle |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 16 | Stack write address |
| stk_data | output | 8 | Stack write byte |
| pc_load | output | 1 | Load new core state |
| pc_new | output | 16 | New program counter |
| pbr_new | output | 8 | New program bank |
| psw_new | output | 8 | New status byte |
| sp_new | output | 16 | New stack pointer |
| src_flag | output | 4 | Status flag per source |
| src_clr | output | 4 | Clear bit per source |

## Verification
Each kind of wrong internal state shows up at the ports in a different way and at a different time:
- A wrong clear bit or status flag shows on `src_clr` or `src_flag` in the cycle after the edge that corrupted it.
- A mis-sequenced state machine shows at once as a stack write at the wrong address, a bank push in emulation mode, or `pc_load` arriving early or late. The behavioural model compares every such output on every cycle.
- A wrong priority or mask decision shows in the first pending cycle as a wrong `irq_src` or `irq_vector`.
- A stale snapshot of the core state surfaces only in the pushed bytes and in the load cycle, up to seven cycles after acceptance.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int NSRC  = 4;
  localparam int SRC_W = $clog2(NSRC);
  localparam int PSW_I = 2;
  localparam int PSW_D = 3;
  localparam int PSW_B = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DUMMY, ST_INTERNAL, ST_PB, ST_PCH, ST_PCL, ST_PSW, ST_LOAD
  } seq_e;
endpackage

// File: rtl/irqarb_select.sv
module irqarb_select
  import irqarb_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  en,
  input  logic [NSRC-1:0]  clr,
  input  logic             dis,
  output logic             take,
  output logic [SRC_W-1:0] src
);
  logic [NSRC-1:0] elig;

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    if (i == 0) begin : g_nmi
      assign elig[i] = req[i] & ~clr[i];
    end else begin : g_mask
      assign elig[i] = req[i] & en[i] & ~clr[i] & ~dis;
    end
  end

  always_comb begin
    take = |elig;
    src  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) src = SRC_W'(i);
    end
  end
endmodule

// File: rtl/irqarb_flags.sv
module irqarb_flags
  import irqarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [SRC_W-1:0] acc_src,
  input  logic [NSRC-1:0]  clr_set,
  input  logic [NSRC-1:0]  clr_drop,
  output logic [NSRC-1:0]  clr_q,
  output logic [NSRC-1:0]  sts_q
);
  logic [NSRC-1:0] acc_vec;
  logic [NSRC-1:0] self_clr;
  logic [NSRC-1:0] clr_d, sts_d;
  logic            clr_en, sts_en;

  always_comb begin
    acc_vec  = '0;
    self_clr = '0;
    if (accept) begin
      acc_vec[acc_src] = 1'b1;
      self_clr[0]      = (acc_src == '0);
    end
    clr_d  = (clr_q & ~clr_drop) | clr_set | self_clr;
    sts_d  = (sts_q & ~clr_set) | acc_vec;
    clr_en = |{clr_set, clr_drop, self_clr};
    sts_en = |{clr_set, acc_vec};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
    end else if (clr_en) begin
      clr_q <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end
endmodule

// File: rtl/irqarb_entry.sv
module irqarb_entry
  import irqarb_pkg::*;
#(
  parameter int         BW       = 8,
  parameter int         AW       = 2 * BW,
  parameter logic [7:0] EMU_PAGE = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SRC_W-1:0] src_in,
  input  logic [AW-1:0]    vec_in,
  input  logic [AW-1:0]    pc_in,
  input  logic [BW-1:0]    pbr_in,
  input  logic [BW-1:0]    psw_in,
  input  logic [AW-1:0]    sp_in,
  input  logic             emu_in,
  output logic             busy,
  output logic             pending,
  output logic             dummy_rd,
  output logic [SRC_W-1:0] src_q,
  output logic [AW-1:0]    vec_q,
  output logic             emu_q,
  output logic             stk_we,
  output logic [AW-1:0]    stk_addr,
  output logic [BW-1:0]    stk_data,
  output logic             load,
  output logic [BW-1:0]    psw_new,
  output logic [AW-1:0]    sp_q
);
  seq_e             st_q, st_d;
  logic [AW-1:0]    pc_q;
  logic [BW-1:0]    pbr_q, psw_q;
  logic [AW-1:0]    sp_d;
  logic             snap;

  function automatic logic [AW-1:0] sp_dec(input logic [AW-1:0] s, input logic e);
    if (e) sp_dec = {EMU_PAGE, s[BW-1:0] - BW'(1)};
    else   sp_dec = s - AW'(1);
  endfunction

  always_comb begin
    st_d = st_q;
    sp_d = sp_q;
    snap = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_DUMMY;
          snap = 1'b1;
          sp_d = emu_in ? {EMU_PAGE, sp_in[BW-1:0]} : sp_in;
        end
      end
      ST_DUMMY:    st_d = ST_INTERNAL;
      ST_INTERNAL: st_d = emu_q ? ST_PCH : ST_PB;
      ST_PB:  begin st_d = ST_PCH; sp_d = sp_dec(sp_q, emu_q); end
      ST_PCH: begin st_d = ST_PCL; sp_d = sp_dec(sp_q, emu_q); end
      ST_PCL: begin st_d = ST_PSW; sp_d = sp_dec(sp_q, emu_q); end
      ST_PSW: begin st_d = ST_LOAD; sp_d = sp_dec(sp_q, emu_q); end
      ST_LOAD:     st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      sp_q <= '0;
    end else begin
      st_q <= st_d;
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      vec_q <= '0;
      pc_q  <= '0;
      pbr_q <= '0;
      psw_q <= '0;
      emu_q <= 1'b0;
    end else if (snap) begin
      src_q <= src_in;
      vec_q <= vec_in;
      pc_q  <= pc_in;
      pbr_q <= pbr_in;
      psw_q <= psw_in;
      emu_q <= emu_in;
    end
  end

  always_comb begin
    busy     = (st_q != ST_IDLE);
    pending  = (st_q == ST_DUMMY);
    dummy_rd = (st_q == ST_DUMMY);
    load     = (st_q == ST_LOAD);
    stk_we   = (st_q == ST_PB) || (st_q == ST_PCH) || (st_q == ST_PCL) || (st_q == ST_PSW);
    stk_addr = stk_we ? sp_q : '0;
    stk_data = '0;
    unique case (st_q)
      ST_PB:   stk_data = pbr_q;
      ST_PCH:  stk_data = pc_q[AW-1:BW];
      ST_PCL:  stk_data = pc_q[BW-1:0];
      ST_PSW:  stk_data = emu_q ? (psw_q & ~(BW'(1) << PSW_B)) : psw_q;
      default: stk_data = '0;
    endcase
    psw_new = (psw_q | (BW'(1) << PSW_I)) & ~(BW'(1) << PSW_D);
  end
endmodule

// File: rtl/irqarb_top.sv
module irqarb_top
  import irqarb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_end,
  input  logic [3:0]  src_req,
  input  logic [3:0]  src_en,
  input  logic [3:0]  clr_set,
  input  logic [3:0]  clr_drop,
  input  logic [15:0] nmi_vec,
  input  logic [15:0] irq_vec,
  input  logic [15:0] core_pc,
  input  logic [7:0]  core_pbr,
  input  logic [7:0]  core_psw,
  input  logic [15:0] core_sp,
  input  logic        core_emu,
  output logic        irq_pending,
  output logic [1:0]  irq_src,
  output logic [15:0] irq_vector,
  output logic        core_wake,
  output logic        dummy_rd,
  output logic        stk_we,
  output logic [15:0] stk_addr,
  output logic [7:0]  stk_data,
  output logic        pc_load,
  output logic [15:0] pc_new,
  output logic [7:0]  pbr_new,
  output logic [7:0]  psw_new,
  output logic [15:0] sp_new,
  output logic [3:0]  src_flag,
  output logic [3:0]  src_clr
);
  logic             take, busy, accept, load, emu_q;
  logic [SRC_W-1:0] sel_src, src_q;
  logic [15:0]      sel_vec, vec_q, sp_q;

  irqarb_select u_sel (
    .req (src_req),
    .en  (src_en),
    .clr (src_clr),
    .dis (core_psw[PSW_I]),
    .take(take),
    .src (sel_src)
  );

  assign accept  = insn_end & ~busy & take;
  assign sel_vec = (sel_src == '0) ? nmi_vec : irq_vec;

  irqarb_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .acc_src (sel_src),
    .clr_set (clr_set),
    .clr_drop(clr_drop),
    .clr_q   (src_clr),
    .sts_q   (src_flag)
  );

  irqarb_entry #(.BW(8)) u_entry (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .src_in  (sel_src),
    .vec_in  (sel_vec),
    .pc_in   (core_pc),
    .pbr_in  (core_pbr),
    .psw_in  (core_psw),
    .sp_in   (core_sp),
    .emu_in  (core_emu),
    .busy    (busy),
    .pending (irq_pending),
    .dummy_rd(dummy_rd),
    .src_q   (src_q),
    .vec_q   (vec_q),
    .emu_q   (emu_q),
    .stk_we  (stk_we),
    .stk_addr(stk_addr),
    .stk_data(stk_data),
    .load    (load),
    .psw_new (psw_new),
    .sp_q    (sp_q)
  );

  assign irq_src    = src_q;
  assign irq_vector = vec_q;
  assign core_wake  = irq_pending;
  assign pc_load    = load;
  assign pc_new     = load ? vec_q : 16'h0000;
  assign pbr_new    = 8'h00;
  assign sp_new     = sp_q;
endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_end,
  input logic [7:0]  core_psw,
  input logic        irq_pending,
  input logic [1:0]  irq_src,
  input logic        core_wake,
  input logic        stk_we,
  input logic [15:0] stk_addr,
  input logic        pc_load,
  input logic        emu_q,
  input logic [3:0]  src_flag,
  input logic [3:0]  src_clr
);
  AST_PEND_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> $past(insn_end)); // R1
  AST_PEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |=> !irq_pending); // R1
  AST_NMI_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && irq_src == 2'd0) |-> src_clr[0]); // R3
  AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && irq_src != 2'd0) |-> $past(!core_psw[2])); // R4
  AST_FLAG_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> src_flag[irq_src]); // R5
  AST_WAKE_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    core_wake == irq_pending); // R6
  AST_WE_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && pc_load)); // R7
  AST_EMU_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && emu_q) |-> stk_addr[15:8] == 8'h01); // R8
  AST_LOAD_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(stk_we)); // R9
endmodule

bind irqarb_top irqarb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_end   (insn_end),
  .core_psw   (core_psw),
  .irq_pending(irq_pending),
  .irq_src    (irq_src),
  .core_wake  (core_wake),
  .stk_we     (stk_we),
  .stk_addr   (stk_addr),
  .pc_load    (pc_load),
  .emu_q      (u_entry.emu_q),
  .src_flag   (src_flag),
  .src_clr    (src_clr)
);

// File: tb/irqarb_top_test.sv
`timescale 1ns/1ps
module irqarb_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_end;
  logic [3:0]  src_req, src_en, clr_set, clr_drop;
  logic [15:0] nmi_vec, irq_vec, core_pc, core_sp;
  logic [7:0]  core_pbr, core_psw;
  logic        core_emu;
  logic        irq_pending, core_wake, dummy_rd, stk_we, pc_load;
  logic [1:0]  irq_src;
  logic [15:0] irq_vector, stk_addr, pc_new, sp_new;
  logic [7:0]  stk_data, pbr_new, psw_new;
  logic [3:0]  src_flag, src_clr;

  always #2 clk = ~clk;

  irqarb_top uut (.*);

  int n_chk = 0, n_fail = 0, n_take = 0, exp_take = 0;
  logic [1:0] last_src;
  bit done = 0;

  // model state: entry = {pend, rd, we, ld, addr[15:0], data[7:0]}
  logic [27:0] exp_q[$];
  logic [3:0]  m_clr, m_sts, m_acc, m_self;
  logic [15:0] m_vec, m_spf, m_s;
  logic [7:0]  m_pnew;
  logic [1:0]  m_src;
  logic [27:0] e;
  bit          m_busy;
  int          cand;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] ent(bit p, bit r, bit w, bit l, logic [15:0] a, logic [7:0] d);
    return {p, r, w, l, a, d};
  endfunction

  function automatic logic [15:0] dec(logic [15:0] s, bit em);
    return em ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      m_clr = '0;
      m_sts = '0;
    end else begin
      m_busy = exp_q.size() != 0;
      if (m_busy) void'(exp_q.pop_front());
      cand = -1;
      if (src_req[0] && !m_clr[0]) cand = 0;
      else if (!core_psw[2]) begin
        if (src_req[1] && src_en[1] && !m_clr[1]) cand = 1;
        else if (src_req[2] && src_en[2] && !m_clr[2]) cand = 2;
        else if (src_req[3] && src_en[3] && !m_clr[3]) cand = 3;
      end
      m_acc = '0;
      m_self = '0;
      if (!m_busy && insn_end && cand >= 0) begin
        m_acc[cand] = 1'b1;
        if (cand == 0) m_self[0] = 1'b1;
        m_src  = 2'(cand);
        m_vec  = (cand == 0) ? nmi_vec : irq_vec;
        m_pnew = (core_psw | 8'h04) & ~8'h08;
        m_s    = core_emu ? {8'h01, core_sp[7:0]} : core_sp;
        exp_q.push_back(ent(1, 1, 0, 0, 0, 0));
        exp_q.push_back(ent(0, 0, 0, 0, 0, 0));
        if (!core_emu) begin
          exp_q.push_back(ent(0, 0, 1, 0, m_s, core_pbr)); m_s = dec(m_s, core_emu);
        end
        exp_q.push_back(ent(0, 0, 1, 0, m_s, core_pc[15:8])); m_s = dec(m_s, core_emu);
        exp_q.push_back(ent(0, 0, 1, 0, m_s, core_pc[7:0]));  m_s = dec(m_s, core_emu);
        exp_q.push_back(ent(0, 0, 1, 0, m_s, core_emu ? (core_psw & ~8'h10) : core_psw));
        m_s = dec(m_s, core_emu);
        exp_q.push_back(ent(0, 0, 0, 1, 0, 0));
        m_spf = m_s;
      end
      m_clr = (m_clr & ~clr_drop) | clr_set | m_self;
      m_sts = (m_sts & ~clr_set) | m_acc;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      e = (exp_q.size() != 0) ? exp_q[0] : '0;
      if (irq_pending) begin n_take++; last_src = irq_src; end
      chk(irq_pending == e[27], "R1 pending", irq_pending, e[27]);
      chk(core_wake == e[27], "R6 wake", core_wake, e[27]);
      chk(dummy_rd == e[26], "R7 dummy read", dummy_rd, e[26]);
      chk(stk_we == e[25], "R7 stack write", stk_we, e[25]);
      chk(pc_load == e[24], "R9 load strobe", pc_load, e[24]);
      if (e[25]) begin
        chk(stk_addr == e[23:8], "R8 stack address", stk_addr, e[23:8]);
        chk(stk_data == e[7:0], "R7 stack byte", stk_data, e[7:0]);
      end
      if (e[27]) begin
        chk(irq_vector == m_vec, "R5 vector", irq_vector, m_vec);
        chk(irq_src == m_src, "R4 source", irq_src, m_src);
      end
      if (e[24]) begin
        chk(pc_new == m_vec, "R9 pc", pc_new, m_vec);
        chk(pbr_new == 8'h00, "R9 bank", pbr_new, 0);
        chk(psw_new == m_pnew, "R9 status", psw_new, m_pnew);
        chk(sp_new == m_spf, "R9 sp", sp_new, m_spf);
      end
      chk(src_flag == m_sts, "R5 status flags", src_flag, m_sts);
      chk(src_clr == m_clr, "R10 clear bits", src_clr, m_clr);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic end_insn();
    insn_end = 1'b1; step(1); insn_end = 1'b0;
  endtask

  task automatic pset(input logic [3:0] v);
    clr_set = v; step(1); clr_set = '0;
  endtask

  task automatic pdrop(input logic [3:0] v);
    clr_drop = v; step(1); clr_drop = '0;
  endtask

  task automatic expect_take(input int add, input logic [1:0] src, input string tag);
    exp_take += add;
    chk(n_take == exp_take, {tag, " take count"}, n_take, exp_take);
    if (add > 0) chk(last_src == src, {tag, " source"}, last_src, src);
  endtask

  task automatic summary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; insn_end = 0; src_req = 0; src_en = 0; clr_set = 0; clr_drop = 0;
    nmi_vec = 16'hfeea; irq_vec = 16'hbe11; core_pc = 16'h1234; core_pbr = 8'h7e;
    core_psw = 8'h04; core_sp = 16'h01f0; core_emu = 0;
    step(3);
    // R11 reset state
    chk(src_flag == 0 && src_clr == 0, "R11 reset flags", {src_flag, src_clr}, 0);
    chk(!irq_pending && !stk_we && !pc_load, "R11 reset outputs", {irq_pending, stk_we, pc_load}, 0);
    rst_n = 1; step(2);

    // R2 non-maskable taken with disable flag set
    src_req = 4'b0001; end_insn(); step(10);
    expect_take(1, 0, "R2");
    // R3 held request not retaken
    end_insn(); step(10);
    expect_take(0, 0, "R3");
    chk(src_clr[0] == 1'b1, "R3 self clear", src_clr[0], 1);
    // R10 set clears flag, drop releases clear bit
    pset(4'b0001); step(1);
    chk(src_flag[0] == 1'b0, "R10 flag dropped", src_flag[0], 0);
    src_req = 0; pdrop(4'b0001); step(1);
    chk(src_clr[0] == 1'b0, "R10 clear released", src_clr[0], 0);

    // R4 priority among maskable sources
    core_psw = 8'h18; src_req = 4'b1110; src_en = 4'b1110;
    core_pc = 16'h8421; core_sp = 16'h1f80;
    end_insn(); step(10); expect_take(1, 1, "R4 timer first");
    pset(4'b0010); end_insn(); step(10); expect_take(1, 2, "R4 dma second");
    pset(4'b0100); end_insn(); step(10); expect_take(1, 3, "R4 host third");
    // R4 disable flag blocks maskables
    pdrop(4'b1110); core_psw = 8'h1c; end_insn(); step(10);
    expect_take(0, 0, "R4 masked");
    // R4 enable low blocks
    core_psw = 8'h18; src_en = 0; end_insn(); step(10);
    expect_take(0, 0, "R4 disabled source");
    // R4 non-maskable above timer
    src_en = 4'b0010; src_req = 4'b0011; end_insn(); step(10);
    expect_take(1, 0, "R4 nmi over timer");

    // R7 R8 emulation mode frame
    core_emu = 1; core_sp = 16'h2101; core_psw = 8'h38; core_pc = 16'hc0de;
    src_req = 4'b0010; end_insn(); step(10);
    expect_take(1, 1, "R7 emulation");
    core_sp = 16'h2100; pset(4'b0010); pdrop(4'b0010); end_insn(); step(10);
    expect_take(1, 1, "R8 page wrap");
    core_emu = 0;

    // R12 strobe while busy ignored
    pset(4'b0010); src_req = 4'b1000; src_en = 4'b1000;
    end_insn(); step(2); end_insn(); src_req = 0; step(10);
    expect_take(1, 3, "R12");
    summary();
  end
endmodule